// File: doc/BRIEF.md
# Multi-Lane Serial Register Port

This block is the slave side of a serial register interface. A master selects it with an active-low chip select, toggles a serial clock and moves data over one, two or four data lanes. Every access opens with an instruction byte that names the target register and says whether the access is a read or a write. A data phase then follows. Its length is the byte width of the addressed register, taken from a parameter table. Accesses therefore work on whole registers rather than single bytes.

The serial clock is oversampled by the system clock. Write bytes leave the block as one-cycle byte strobes toward an external register bank. Read data is taken from the bank's combinational read port and driven onto the output lanes after each falling serial-clock edge. A resync input, or releasing chip select, abandons the access in progress. Bytes that were already complete have been written by then. A partly shifted byte is dropped.

Top module: `mlsp_port`

## Requirements
- R1: The first 8 bits after reset, after a completed access, or after an abort form the instruction byte. Bits are sent MSB first. Bit 7 = 1 selects a read and bit 7 = 0 a write. Bits 4:0 give the register address.
- R2: Lane bits are captured on each rising serial-clock edge. Register bytes travel most significant byte first. Each completed write byte produces one `wr_en` pulse carrying `wr_addr`, the byte's significance in `wr_byte` (0 = least significant) and `wr_data`.
- R3: The data phase length equals the byte width of the addressed register, from the `REG_BYTES` table (4 bits per address, address 0 in the lowest nibble). The rising edges that follow the last byte start a new instruction without a chip-select toggle.
- R4: `lane_mode` 0 takes 1 bit per edge on lane 0. Mode 1 takes 2 bits on lanes 1:0, with lane 1 the more significant. Mode 2 takes 4 bits on lanes 3:0, with lane 3 the most significant. Mode 3 acts as mode 0.
- R5: Read data changes only after a falling serial-clock edge and is sent MSB first. In mode 0 it appears on lane 2 with `sdio_oe` = 0100. In mode 1 it uses lanes 1:0 with `sdio_oe` = 0011, and in mode 2 lanes 3:0 with `sdio_oe` = 1111. `sdio_oe` is 0 outside a read data phase.
- R6: Raising `resync` or `cs_n` aborts the access. Bytes completed before the abort stay written. The partial byte produces no strobe. The next 8 bits are an instruction.
- R7: An address at or above `REG_COUNT` acts as a one-byte register. Writes to it produce no strobe, and reads of it return zero.
- R8: After reset, `wr_en` is 0, `sdio_oe` is 0 and the block expects an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_mode | input | 2 | Lane mode from the control register |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| resync | input | 1 | Abort / resynchronise request |
| sdio_in | input | 4 | Data lanes, input side |
| sdio_out | output | 4 | Data lanes, output side |
| sdio_oe | output | 4 | Per-lane output enable |
| rd_addr | output | 5 | Address presented to the bank read port |
| rd_data | input | 32 | Bank read data, register value right-aligned |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 5 | Register address of the strobed byte |
| wr_byte | output | 2 | Byte significance within the register |
| wr_data | output | 8 | Byte value |

## Verification
The assertions check the legal output-enable patterns and the single-cycle width of each strobe on every cycle. They also check that a strobe never targets an unimplemented address or a byte beyond the register's width, and that no strobe follows a cycle with chip select high or resync raised. The bench scenarios are the only way to show byte ordering, exact lane packing per mode, correct data-phase lengths across back-to-back accesses, partial commits on abort, and zero readback from unimplemented addresses.

// File: rtl/mlsp_pkg.sv
package mlsp_pkg;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        LM_ONE  = 2'd0,
        LM_TWO  = 2'd1,
        LM_FOUR = 2'd2,
        LM_RSVD = 2'd3
    } lane_mode_e;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    function automatic logic [3:0] bits_per_edge(lane_mode_e m);
        case (m)
            LM_TWO:  return 4'd2;
            LM_FOUR: return 4'd4;
            default: return 4'd1;
        endcase
    endfunction
endpackage

// File: rtl/mlsp_edge.sv
module mlsp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/mlsp_width.sv
module mlsp_width #(
    parameter int                       REG_COUNT = 8,
    parameter int                       NB_W      = 3,
    parameter logic [REG_COUNT*4-1:0]   REG_BYTES = 32'h1244_4231
) (
    input  logic [mlsp_pkg::ADDR_W-1:0] addr,
    output logic [NB_W-1:0]             nbytes,
    output logic                        valid
);
    logic [REG_COUNT-1:0] hit;
    logic [NB_W-1:0]      wtab [REG_COUNT];

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_ent
        assign hit[i]  = (addr == mlsp_pkg::ADDR_W'(i));
        assign wtab[i] = REG_BYTES[i*4 +: NB_W];
    end

    always_comb begin
        valid  = |hit;
        nbytes = NB_W'(1);
        for (int i = 0; i < REG_COUNT; i++) begin
            if (hit[i]) nbytes = wtab[i];
        end
    end
endmodule

// File: rtl/mlsp_lane.sv
module mlsp_lane (
    input  mlsp_pkg::lane_mode_e mode,
    input  logic [3:0]           lanes,
    input  logic [7:0]           shreg,
    output logic [7:0]           shifted
);
    always_comb begin
        case (mode)
            mlsp_pkg::LM_TWO:  shifted = {shreg[5:0], lanes[1:0]};
            mlsp_pkg::LM_FOUR: shifted = {shreg[3:0], lanes[3:0]};
            default:           shifted = {shreg[6:0], lanes[0]};
        endcase
    end
endmodule

// File: rtl/mlsp_port.sv
module mlsp_port #(
    parameter int                     MAX_BYTES = 4,
    parameter int                     REG_COUNT = 8,
    parameter logic [REG_COUNT*4-1:0] REG_BYTES = 32'h1244_4231
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           lane_mode,
    input  logic                 sclk,
    input  logic                 cs_n,
    input  logic                 resync,
    input  logic [3:0]           sdio_in,
    output logic [3:0]           sdio_out,
    output logic [3:0]           sdio_oe,
    output logic [4:0]           rd_addr,
    input  logic [MAX_BYTES*8-1:0] rd_data,
    output logic                 wr_en,
    output logic [4:0]           wr_addr,
    output logic [$clog2(MAX_BYTES)-1:0] wr_byte,
    output logic [7:0]           wr_data
);
    import mlsp_pkg::*;

    localparam int BIDX_W = $clog2(MAX_BYTES);
    localparam int NB_W   = BIDX_W + 1;

    typedef struct packed {
        phase_e              phase;
        logic [3:0]          cnt;
        logic [7:0]          shreg;
        logic                rw;
        logic [ADDR_W-1:0]   addr;
        logic [BIDX_W-1:0]   idx;
        logic [3:0]          out;
        logic [3:0]          oe;
        logic                wr_en;
        logic [ADDR_W-1:0]   wr_addr;
        logic [BIDX_W-1:0]   wr_byte;
        logic [7:0]          wr_data;
    } state_t;

    state_t st_d, st_q;

    logic              rise, fall;
    lane_mode_e        mode;
    logic [3:0]        kbits;
    logic [7:0]        shifted;
    logic [NB_W-1:0]   nbytes;
    logic              valid;
    logic [BIDX_W-1:0] last_idx;
    logic [BIDX_W-1:0] sig_cur;
    logic [7:0]        rbyte;
    logic [7:0]        chunk;
    logic              byte_done;

    assign mode  = lane_mode_e'(lane_mode);
    assign kbits = bits_per_edge(mode);

    mlsp_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (rise),
        .fall  (fall)
    );

    mlsp_lane u_lane (
        .mode    (mode),
        .lanes   (sdio_in),
        .shreg   (st_q.shreg),
        .shifted (shifted)
    );

    mlsp_width #(
        .REG_COUNT (REG_COUNT),
        .NB_W      (NB_W),
        .REG_BYTES (REG_BYTES)
    ) u_width (
        .addr   (st_q.addr),
        .nbytes (nbytes),
        .valid  (valid)
    );

    assign last_idx  = BIDX_W'(nbytes - NB_W'(1));
    assign sig_cur   = last_idx - st_q.idx;
    assign byte_done = (st_q.cnt + kbits) == 4'd8;
    assign rbyte     = valid ? rd_data[sig_cur*8 +: 8] : 8'h00;
    assign chunk     = rbyte >> (4'd8 - st_q.cnt - kbits);

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (cs_n || resync) begin
            st_d.phase = PH_INSTR;
            st_d.cnt   = 4'd0;
            st_d.oe    = 4'b0000;
            st_d.out   = 4'b0000;
        end else if (rise) begin
            st_d.shreg = shifted;
            st_d.cnt   = st_q.cnt + kbits;
            if (byte_done) begin
                st_d.cnt = 4'd0;
                if (st_q.phase == PH_INSTR) begin
                    st_d.rw    = shifted[7];
                    st_d.addr  = shifted[ADDR_W-1:0];
                    st_d.idx   = '0;
                    st_d.phase = PH_DATA;
                end else begin
                    if (!st_q.rw && valid) begin
                        st_d.wr_en   = 1'b1;
                        st_d.wr_addr = st_q.addr;
                        st_d.wr_byte = sig_cur;
                        st_d.wr_data = shifted;
                    end
                    if (st_q.idx == last_idx) begin
                        st_d.phase = PH_INSTR;
                        st_d.oe    = 4'b0000;
                    end else begin
                        st_d.idx = st_q.idx + BIDX_W'(1);
                    end
                end
            end
        end else if (fall && st_q.phase == PH_DATA && st_q.rw) begin
            case (mode)
                LM_TWO: begin
                    st_d.out = {2'b00, chunk[1:0]};
                    st_d.oe  = 4'b0011;
                end
                LM_FOUR: begin
                    st_d.out = chunk[3:0];
                    st_d.oe  = 4'b1111;
                end
                default: begin
                    st_d.out = {1'b0, chunk[0], 2'b00};
                    st_d.oe  = 4'b0100;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdio_out = st_q.out;
    assign sdio_oe  = st_q.oe;
    assign rd_addr  = st_q.addr;
    assign wr_en    = st_q.wr_en;
    assign wr_addr  = st_q.wr_addr;
    assign wr_byte  = st_q.wr_byte;
    assign wr_data  = st_q.wr_data;
endmodule

// File: rtl/mlsp_port_chk.sv
module mlsp_port_chk #(
    parameter int                     MAX_BYTES = 4,
    parameter int                     REG_COUNT = 8,
    parameter logic [REG_COUNT*4-1:0] REG_BYTES = 32'h1244_4231
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cs_n,
    input logic                         resync,
    input logic [3:0]                   sdio_oe,
    input logic                         wr_en,
    input logic [4:0]                   wr_addr,
    input logic [$clog2(MAX_BYTES)-1:0] wr_byte
);
    function automatic int width_of(logic [4:0] a);
        int w;
        w = 1;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (a == 5'(i)) w = int'(REG_BYTES[i*4 +: 4]);
        end
        return w;
    endfunction

    // R5: only the lane groups of the three modes may be enabled
    a_r5_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe == 4'b0000 || sdio_oe == 4'b0100 ||
         sdio_oe == 4'b0011 || sdio_oe == 4'b1111));

    // R2: each strobe lasts one cycle
    a_r2_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R7: no strobe toward an unimplemented address
    a_r7_no_unimpl_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < REG_COUNT));

    // R3: strobed byte lies within the register width
    a_r3_byte_in_width: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_byte) < width_of(wr_addr)));

    // R6: no strobe after a deselected or resync cycle
    a_r6_no_write_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n || resync) |-> !wr_en);
endmodule

bind mlsp_port mlsp_port_chk #(
    .MAX_BYTES (MAX_BYTES),
    .REG_COUNT (REG_COUNT),
    .REG_BYTES (REG_BYTES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .resync  (resync),
    .sdio_oe (sdio_oe),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_byte (wr_byte)
);

// File: tb/mlsp_port_test.sv
module mlsp_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lane_mode = 2'd0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        resync = 1'b0;
    logic [3:0]  sdio_in = 4'd0;
    logic [3:0]  sdio_out, sdio_oe;
    logic [4:0]  rd_addr;
    logic [31:0] rd_data;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [1:0]  wr_byte;
    logic [7:0]  wr_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        logic [4:0] addr;
        logic [1:0] bidx;
        logic [7:0] data;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    mlsp_port uut (
        .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .sclk(sclk),
        .cs_n(cs_n), .resync(resync), .sdio_in(sdio_in), .sdio_out(sdio_out),
        .sdio_oe(sdio_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte), .wr_data(wr_data)
    );

    // bench-side bank read port
    always_comb begin
        case (rd_addr)
            5'd1:    rd_data = 32'h005A_3C96;
            5'd5:    rd_data = 32'hDEAD_BEEF;
            5'd6:    rd_data = 32'h0000_C3A5;
            5'd20:   rd_data = 32'hFFFF_FFFF;
            default: rd_data = 32'h1111_1111;
        endcase
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected strobe: actual addr=%0d byte=%0d data=%h expected none",
                         wr_addr, wr_byte, wr_data);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (wr_addr !== e.addr || wr_byte !== e.bidx || wr_data !== e.data) begin
                    bad++;
                    $display("FAIL %s strobe: actual addr=%0d byte=%0d data=%h expected addr=%0d byte=%0d data=%h",
                             e.req, wr_addr, wr_byte, wr_data, e.addr, e.bidx, e.data);
                end
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual cycles=%0d expected fewer", cyc);
            summary();
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] expv, string what);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic clk_n(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int kb();
        if (lane_mode == 2'd1) return 2;
        if (lane_mode == 2'd2) return 4;
        return 1;
    endfunction

    function automatic logic [3:0] oe_mask();
        if (lane_mode == 2'd1) return 4'b0011;
        if (lane_mode == 2'd2) return 4'b1111;
        return 4'b0100;
    endfunction

    task automatic put(logic [3:0] v);
        sdio_in = v;
        sclk = 1'b0;
        clk_n(2);
        sclk = 1'b1;
        clk_n(2);
        sclk = 1'b0;
    endtask

    task automatic send_bits(logic [7:0] b, int nunits);
        int k;
        k = kb();
        for (int i = 0; i < nunits; i++) begin
            logic [7:0] v;
            v = (b >> (8 - k - i * k)) & 8'((1 << k) - 1);
            put(v[3:0]);
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        send_bits(b, 8 / kb());
    endtask

    task automatic push(logic [4:0] a, logic [1:0] bi, logic [7:0] d, string req);
        exp_t e;
        e.addr = a; e.bidx = bi; e.data = d; e.req = req;
        sb.push_back(e);
    endtask

    task automatic do_write(logic [4:0] a, int nb, logic [31:0] val, bit expect_strobe, string req);
        if (expect_strobe)
            for (int i = nb - 1; i >= 0; i--) push(a, 2'(i), val[i*8 +: 8], req);
        send_byte({3'b000, a});
        for (int i = nb - 1; i >= 0; i--) send_byte(val[i*8 +: 8]);
    endtask

    task automatic drain(string req);
        clk_n(3);
        check(req, 32'(sb.size()), 32'd0, "pending strobes");
        sb.delete();
    endtask

    task automatic do_read(logic [4:0] a, int nb, logic [31:0] expv, string req);
        logic [31:0] acc;
        bit oe_bad;
        int k;
        acc = '0;
        oe_bad = 0;
        k = kb();
        send_byte({3'b100, a});
        for (int u = 0; u < nb * 8 / k; u++) begin
            logic [3:0] v;
            sclk = 1'b0;
            clk_n(2);
            if (k == 1) v = {3'b000, sdio_out[2]};
            else if (k == 2) v = {2'b00, sdio_out[1:0]};
            else v = sdio_out;
            if (sdio_oe !== oe_mask()) oe_bad = 1;
            acc = (acc << k) | 32'(v);
            sclk = 1'b1;
            clk_n(2);
            sclk = 1'b0;
        end
        check(req, acc, expv, "read value");
        check("R5", 32'(oe_bad), 32'd0, "output enable during read");
        clk_n(2);
        check("R5", 32'(sdio_oe), 32'd0, "output enable after read");
    endtask

    initial begin
        clk_n(3);
        // R8 reset state
        check("R8", 32'(wr_en), 32'd0, "strobe in reset");
        check("R8", 32'(sdio_oe), 32'd0, "oe in reset");
        rst_n = 1'b1;
        clk_n(2);
        check("R8", 32'(sdio_oe), 32'd0, "oe after reset");
        cs_n = 1'b0;
        clk_n(2);

        // R1 R2 R3: three-byte write, then a one-byte write with no deselect
        lane_mode = 2'd0;
        do_write(5'd1, 3, 32'h00AA_BBCC, 1, "R2");
        do_write(5'd0, 1, 32'h0000_0042, 1, "R3");
        drain("R3");

        // R4 dual-lane write
        lane_mode = 2'd1;
        do_write(5'd2, 2, 32'h0000_1E87, 1, "R4");
        drain("R4");

        // R4 quad-lane write
        lane_mode = 2'd2;
        do_write(5'd3, 4, 32'h1234_F0E1, 1, "R4");
        drain("R4");

        // R5 reads in each mode; R1 read flag
        lane_mode = 2'd0;
        do_read(5'd1, 3, 32'h005A_3C96, "R5");
        lane_mode = 2'd2;
        do_read(5'd6, 2, 32'h0000_C3A5, "R5");
        lane_mode = 2'd1;
        do_read(5'd5, 4, 32'hDEAD_BEEF, "R5");

        // R4 reserved mode acts as single lane
        lane_mode = 2'd3;
        do_write(5'd7, 1, 32'h0000_005D, 1, "R4");
        drain("R4");

        // R6 resync mid-transfer: two bytes committed, partial dropped
        lane_mode = 2'd0;
        push(5'd3, 2'd3, 8'h9A, "R6");
        push(5'd3, 2'd2, 8'h6B, "R6");
        send_byte(8'h03);
        send_byte(8'h9A);
        send_byte(8'h6B);
        send_bits(8'hE0, 3);
        resync = 1'b1;
        clk_n(2);
        resync = 1'b0;
        clk_n(1);
        do_write(5'd0, 1, 32'h0000_0077, 1, "R6");
        drain("R6");

        // R6 chip select abort in quad mode
        lane_mode = 2'd2;
        push(5'd2, 2'd1, 8'h5C, "R6");
        send_byte(8'h02);
        send_byte(8'h5C);
        send_bits(8'hA0, 1);
        cs_n = 1'b1;
        clk_n(2);
        cs_n = 1'b0;
        clk_n(1);
        do_read(5'd6, 2, 32'h0000_C3A5, "R6");
        drain("R6");

        // R7 unimplemented address: one byte, no strobe, zero readback
        lane_mode = 2'd0;
        do_write(5'd20, 1, 32'h0000_00F3, 0, "R7");
        do_write(5'd7, 1, 32'h0000_0031, 1, "R7");
        drain("R7");
        do_read(5'd20, 1, 32'h0000_0000, "R7");
        do_write(5'd0, 1, 32'h0000_00A9, 1, "R7");
        drain("R7");

        cs_n = 1'b1;
        clk_n(4);
        summary();
    end
endmodule